// File: doc/BRIEF.md
# Shifted-Operand ALU with Condition Flags

This block is the execute stage of a 32-bit data path. Each valid cycle it takes one operation. Operand A arrives directly. The second operand is either a register value or a zero-extended immediate. The second operand always passes through a single-cycle barrel shifter, which can shift left, shift right or rotate right. The ALU then applies one of ten operations: move, move-not, add, subtract, AND, OR, XOR, bit clear, compare and test-equivalence. On the next clock edge it registers the result, a destination write strobe, and any change to the four condition flags: negative, zero, carry and overflow.

The flags change only when the operation carries its set-flags bit. The two compare-style operations exist only to set flags: compare subtracts and test-equivalence XORs, and neither asserts the write strobe. The current carry flag feeds back into the shifter, so a shift of zero leaves the carry as it was. The design has no sequencing states. It holds one register stage (result and strobe) and one flag register, and the flag register updates on a single named condition: valid and set-flags and a defined opcode.

Top module: `shift_alu`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `result` holds the outcome of the operation. Opcodes: 0 move (result = shifted operand), 1 move-not (result = its bitwise inverse). `result` holds its value while `in_valid` is low.
- R2: With `use_imm` = 1 the second operand is `imm_val` zero-extended to 32 bits. With `use_imm` = 0 it is `opnd_b`.
- R3: Shift encodings: `shift_kind` 0 is logical left, 1 is logical right, 2 is rotate right, 3 is no shift. A `shift_amt` of 0 passes the operand through unchanged.
- R4: Opcode 2 computes A + shifted operand. Opcode 3 computes A − shifted operand. Both wrap modulo 2^32.
- R5: Opcodes 4, 5, 6 and 7 compute A AND op, A OR op, A XOR op and A AND NOT op.
- R6: `wr_en` is high in the cycle after a valid cycle with opcodes 0–7. It is low after opcodes 8 (compare, subtract) and 9 (test, XOR) and after idle cycles.
- R7: The flags change only in the cycle after `in_valid` = 1, `set_flags` = 1 and a defined opcode (0–9). Otherwise they hold.
- R8: When the flags update, `flag_n` equals bit 31 of the operation's result, and `flag_z` is 1 exactly when that result is all zero.
- R9: For add, `flag_c` is the carry out of bit 31. For subtract and compare, `flag_c` is 1 when no borrow occurs (A ≥ op unsigned). For all three, `flag_v` flags signed overflow.
- R10: For opcodes 0, 1 and 4–7 and 9, `flag_c` takes the last bit the shifter moved out (for rotate, bit 31 of its output) and `flag_v` is unchanged. A zero shift or no-shift kind keeps `flag_c`.
- R11: After reset, `result` is 0, `wr_en` is 0 and all four flags are 0.
- R12: Opcodes 10–15 are undefined. They give `result` = 0 and `wr_en` = 0, and they leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation select (see R1, R4–R6, R12) |
| set_flags | input | 1 | Allow this operation to update the flags |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Register form of the second operand |
| use_imm | input | 1 | Select the immediate as the second operand |
| imm_val | input | 12 | Immediate literal, zero-extended |
| shift_kind | input | 2 | Shifter mode |
| shift_amt | input | 5 | Shift or rotate distance |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Destination write strobe |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Every stored value reaches the ports one cycle after it is written. A corrupted result or strobe register therefore shows on `result` or `wr_en` on the very next edge. A wrong flag value shows on the flag outputs at once. It also spreads: the carry flag feeds the shifter's carry-in, so a stale carry appears again one operation later as a wrong `flag_c` after any zero-distance logical operation. A flag register that updates when it should hold shows on the next idle or compare cycle with `set_flags` low. For this reason the bench follows every flag-setting operation with both kinds of neighbour.

// File: rtl/shalu_pkg.sv
package shalu_pkg;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 12;
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int OPC_W  = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_MOV = 4'd0,
        OP_MVN = 4'd1,
        OP_ADD = 4'd2,
        OP_SUB = 4'd3,
        OP_AND = 4'd4,
        OP_ORR = 4'd5,
        OP_XOR = 4'd6,
        OP_BIC = 4'd7,
        OP_CMP = 4'd8,
        OP_TST = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL  = 2'd0,
        SH_LSR  = 2'd1,
        SH_ROR  = 2'd2,
        SH_PASS = 2'd3
    } shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic op_known(logic [OPC_W-1:0] op);
        return op <= OP_TST;
    endfunction

    function automatic logic op_writes(logic [OPC_W-1:0] op);
        return op <= OP_BIC;
    endfunction

    function automatic logic op_logical(logic [OPC_W-1:0] op);
        return op == OP_MOV || op == OP_MVN || op == OP_AND || op == OP_ORR ||
               op == OP_XOR || op == OP_BIC || op == OP_TST;
    endfunction

endpackage

// File: rtl/shalu_shifter.sv
module shalu_shifter
    import shalu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  shift_e        kind,
    input  logic [AW-1:0] amt,
    input  logic          carry_in,
    output logic [W-1:0]  dout,
    output logic          carry_out
);

    localparam int STAGES = AW;

    logic [W:0]   lsl_wide;
    logic [W:0]   lsr_wide;
    logic [W-1:0] rot_stage [STAGES+1];

    assign lsl_wide = {1'b0, din} << amt;
    assign lsr_wide = {din, 1'b0} >> amt;

    assign rot_stage[0] = din;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_rot
            localparam int D = 2 ** s;
            assign rot_stage[s+1] = amt[s]
                ? {rot_stage[s][D-1:0], rot_stage[s][W-1:D]}
                : rot_stage[s];
        end
    endgenerate

    always_comb begin
        dout      = din;
        carry_out = carry_in;
        if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    dout      = lsl_wide[W-1:0];
                    carry_out = lsl_wide[W];
                end
                SH_LSR: begin
                    dout      = lsr_wide[W:1];
                    carry_out = lsr_wide[0];
                end
                SH_ROR: begin
                    dout      = rot_stage[STAGES];
                    carry_out = rot_stage[STAGES][W-1];
                end
                SH_PASS: begin
                    dout      = din;
                    carry_out = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/shalu_core.sv
module shalu_core
    import shalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             sh_carry,
    input  flags_t           cur,
    output logic [W-1:0]     res,
    output flags_t           nxt
);

    logic [W:0] sum_w;
    logic [W:0] dif_w;
    logic       add_v;
    logic       sub_v;

    assign sum_w = {1'b0, a} + {1'b0, b};
    assign dif_w = {1'b0, a} - {1'b0, b};
    assign add_v = (a[W-1] == b[W-1]) && (sum_w[W-1] != a[W-1]);
    assign sub_v = (a[W-1] != b[W-1]) && (dif_w[W-1] != a[W-1]);

    always_comb begin
        res   = '0;
        nxt   = cur;
        nxt.c = sh_carry;
        case (opcode)
            OP_MOV: res = b;
            OP_MVN: res = ~b;
            OP_ADD: begin
                res   = sum_w[W-1:0];
                nxt.c = sum_w[W];
                nxt.v = add_v;
            end
            OP_SUB, OP_CMP: begin
                res   = dif_w[W-1:0];
                nxt.c = ~dif_w[W];
                nxt.v = sub_v;
            end
            OP_AND: res = a & b;
            OP_ORR: res = a | b;
            OP_XOR, OP_TST: res = a ^ b;
            OP_BIC: res = a & ~b;
            default: begin
                res   = '0;
                nxt.c = cur.c;
            end
        endcase
        nxt.n = res[W-1];
        nxt.z = (res == '0);
    end

endmodule

// File: rtl/shalu_flags.sv
module shalu_flags
    import shalu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   update,
    input  flags_t nxt,
    output flags_t cur
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (update) begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import shalu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W,
    parameter int AW = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic             set_flags,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic             use_imm,
    input  logic [IW-1:0]    imm_val,
    input  logic [1:0]       shift_kind,
    input  logic [AW-1:0]    shift_amt,
    output logic [W-1:0]     result,
    output logic             wr_en,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);

    logic [W-1:0] op2_raw;
    logic [W-1:0] op2_sh;
    logic         sh_cout;
    logic [W-1:0] alu_res;
    flags_t       flg_cur;
    flags_t       flg_nxt;
    logic         flg_upd;
    logic [W-1:0] result_q;
    logic         wr_en_q;

    assign op2_raw = use_imm ? {{(W-IW){1'b0}}, imm_val} : opnd_b;

    shalu_shifter #(.W(W), .AW(AW)) u_shift (
        .din       (op2_raw),
        .kind      (shift_e'(shift_kind)),
        .amt       (shift_amt),
        .carry_in  (flg_cur.c),
        .dout      (op2_sh),
        .carry_out (sh_cout)
    );

    shalu_core #(.W(W)) u_core (
        .opcode   (opcode),
        .a        (opnd_a),
        .b        (op2_sh),
        .sh_carry (sh_cout),
        .cur      (flg_cur),
        .res      (alu_res),
        .nxt      (flg_nxt)
    );

    assign flg_upd = in_valid && set_flags && op_known(opcode);

    shalu_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .update (flg_upd),
        .nxt    (flg_nxt),
        .cur    (flg_cur)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            wr_en_q  <= 1'b0;
        end else begin
            wr_en_q <= in_valid && op_writes(opcode);
            if (in_valid) begin
                result_q <= alu_res;
            end
        end
    end

    assign result = result_q;
    assign wr_en  = wr_en_q;
    assign flag_n = flg_cur.n;
    assign flag_z = flg_cur.z;
    assign flag_c = flg_cur.c;
    assign flag_v = flg_cur.v;

    assert_no_write_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (opcode == OP_CMP || opcode == OP_TST) |=> !wr_en);

    assert_idle_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_en);

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && set_flags && opcode <= OP_TST) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && set_flags && opcode <= OP_BIC |=> flag_z == (result == '0));

    assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && set_flags && opcode <= OP_BIC |=> flag_n == result[W-1]);

    assert_logic_keeps_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && set_flags && op_logical(opcode) |=> $stable(flag_v));

    assert_move_zero_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == OP_MOV && shift_amt == '0 |=>
        result == $past(use_imm ? {{(W-IW){1'b0}}, imm_val} : opnd_b));

    assert_undefined_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode > OP_TST |=> result == '0 && !wr_en);

endmodule

// File: tb/shift_alu_test.sv
module shift_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        use_imm = 1'b0;
    logic [11:0] imm_val = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic [31:0] result;
    logic        wr_en;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
        string       tag;
    } exp_t;

    exp_t        sb [$];
    logic [31:0] m_res = '0;
    logic [3:0]  m_fl  = '0;

    always #10 clk = ~clk;

    shift_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .set_flags(set_flags), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .use_imm(use_imm), .imm_val(imm_val), .shift_kind(shift_kind),
        .shift_amt(shift_amt), .result(result), .wr_en(wr_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic void ref_shift(input logic [31:0] b, input logic [1:0] k,
                                      input int n, input logic cin,
                                      output logic [31:0] o, output logic co);
        o = b; co = cin;
        if (n != 0 && k != 2'd3) begin
            case (k)
                2'd0: begin o = b << n; co = b[32-n]; end
                2'd1: begin o = b >> n; co = b[n-1]; end
                default: begin o = (b >> n) | (b << (32 - n)); co = o[31]; end
            endcase
        end
    endfunction

    task automatic drive(input logic [3:0] op, input logic sf, input logic [31:0] a,
                         input logic [31:0] b, input logic ui, input logic [11:0] im,
                         input logic [1:0] sk, input logic [4:0] sa, input string tag);
        logic [31:0] s, r;
        logic        sc, c, v;
        logic [32:0] w;
        exp_t        e;
        ref_shift(ui ? {20'd0, im} : b, sk, int'(sa), m_fl[1], s, sc);
        c = sc; v = m_fl[0]; r = '0;
        case (op)
            4'd0: r = s;
            4'd1: r = ~s;
            4'd2: begin w = {1'b0, a} + {1'b0, s}; r = w[31:0]; c = w[32];
                        v = (a[31] == s[31]) && (r[31] != a[31]); end
            4'd3, 4'd8: begin r = a - s; c = (a >= s);
                        v = (a[31] != s[31]) && (r[31] != a[31]); end
            4'd4: r = a & s;
            4'd5: r = a | s;
            4'd6, 4'd9: r = a ^ s;
            4'd7: r = a & ~s;
            default: r = '0;
        endcase
        if (sf && op <= 4'd9) m_fl = {r[31], r == 0, c, v};
        m_res = r;
        @(negedge clk);
        in_valid = 1'b1; opcode = op; set_flags = sf; opnd_a = a; opnd_b = b;
        use_imm = ui; imm_val = im; shift_kind = sk; shift_amt = sa;
        e.res = m_res; e.we = (op <= 4'd7); e.fl = m_fl; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        opcode = 4'd2; set_flags = 1'b1;
        e.res = m_res; e.we = 1'b0; e.fl = m_fl; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.res || wr_en !== e.we ||
                {flag_n, flag_z, flag_c, flag_v} !== e.fl) begin
                fails++;
                $display("FAIL %s: got res=%h we=%b nzcv=%b, expected res=%h we=%b nzcv=%b",
                         e.tag, result, wr_en, {flag_n, flag_z, flag_c, flag_v},
                         e.res, e.we, e.fl);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (result !== 0 || wr_en !== 0 || {flag_n, flag_z, flag_c, flag_v} !== 0) begin
            fails++;
            $display("FAIL R11: got res=%h we=%b nzcv=%b, expected all zero",
                     result, wr_en, {flag_n, flag_z, flag_c, flag_v});
        end
        // R2 immediate, R1 move with zero shift keeps carry (R10)
        drive(4'd0, 1, 0, 32'hDEAD, 1, 12'hABC, 2'd0, 5'd0, "R2 imm move");
        drive(4'd0, 0, 0, 32'h1234_5678, 0, 12'hFFF, 2'd0, 5'd0, "R2 reg move");
        drive(4'd1, 1, 0, 32'h0000_00FF, 0, 0, 2'd3, 5'd7, "R1 move-not");
        // R3 shifts with carry out (R10)
        drive(4'd0, 1, 0, 32'h4000_0001, 0, 0, 2'd0, 5'd2, "R3 lsl carry");
        drive(4'd0, 1, 0, 32'h0000_0003, 0, 0, 2'd1, 5'd1, "R3 lsr carry");
        drive(4'd0, 1, 0, 32'h0000_0001, 0, 0, 2'd2, 5'd1, "R3 ror");
        drive(4'd0, 1, 0, 32'h8000_0000, 0, 0, 2'd0, 5'd1, "R3 lsl to zero");
        // R4 / R9 arithmetic
        drive(4'd2, 1, 32'h7FFF_FFFF, 1, 0, 0, 2'd0, 5'd0, "R9 add overflow");
        idle("R7 idle after add");
        drive(4'd6, 1, 32'hF0F0_0000, 32'h0F0F_0000, 0, 0, 2'd0, 5'd0, "R10 logic keeps V");
        drive(4'd2, 1, 32'hFFFF_FFFF, 1, 0, 0, 2'd0, 5'd0, "R9 add carry zero");
        drive(4'd3, 1, 32'd5, 32'd5, 0, 0, 2'd0, 5'd0, "R4 sub equal");
        drive(4'd3, 1, 32'd1, 32'd2, 0, 0, 2'd0, 5'd0, "R9 sub borrow");
        drive(4'd3, 1, 32'h8000_0000, 1, 0, 0, 2'd0, 5'd0, "R9 sub overflow");
        drive(4'd2, 0, 32'd10, 32'd3, 1, 12'd4, 2'd0, 5'd1, "R7 add no flags");
        // R5 logical
        drive(4'd4, 0, 32'hFF00_FF00, 32'h0FF0_0FF0, 0, 0, 2'd0, 5'd0, "R5 and");
        drive(4'd5, 0, 32'hFF00_0000, 32'h0000_00FF, 0, 0, 2'd0, 5'd4, "R5 or");
        drive(4'd7, 1, 32'hFFFF_FFFF, 32'h0000_000F, 0, 0, 2'd1, 5'd0, "R5 bic");
        // R6 compare forms
        drive(4'd8, 1, 32'd3, 32'd9, 0, 0, 2'd0, 5'd0, "R6 compare");
        drive(4'd9, 1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 0, 2'd0, 5'd0, "R6 test equal");
        drive(4'd8, 0, 32'd9, 32'd3, 0, 0, 2'd0, 5'd0, "R7 compare no flags");
        idle("R6 idle");
        // R12 undefined
        drive(4'd12, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 2'd0, 5'd3, "R12 undefined");
        drive(4'd15, 0, 32'h1, 32'h1, 0, 0, 2'd0, 5'd0, "R12 undefined b");
        for (int i = 0; i < 60; i++) begin
            drive(4'($urandom_range(0, 11)), 1'($urandom), $urandom, $urandom,
                  1'($urandom), 12'($urandom), 2'($urandom), 5'($urandom), "R1 mixed");
            if (i % 7 == 0) idle("R7 mixed idle");
        end
        idle("R6 final idle");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule